// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one unsigned integer by another and returns both the quotient and the remainder. It uses the restoring method and retires one quotient bit per clock, so a division of width `W` takes `W` step cycles. A request is one cycle of `start_i` while the block is idle, with the operands presented alongside it. The block then raises `busy_o`. When the final step has been taken, it drops `busy_o` and pulses `done_o` for one cycle.

Each step shifts the partial remainder left by one position and brings in the top bit of the working dividend. It then trial-subtracts the divisor. The sign of that difference decides two things: the quotient bit that enters on the right, and whether the partial remainder takes the difference or keeps the shifted value. The working dividend shifts left with a zero entering. A zero divisor needs no special handling. Every trial subtraction then succeeds, so the quotient becomes all ones and the remainder ends equal to the dividend.

The results stay on `quotient_o` and `remainder_o` until the next request is accepted. Requests raised while a division is in flight are dropped.

Top module: `seq_divider`

## Requirements
- R1: After reset, busy_o and done_o are low and quotient_o and remainder_o are zero.
- R2: A cycle with start_i high while busy_o is low is accepted: busy_o is high in the following cycle and done_o is low.
- R3: After an accepted request busy_o stays high for exactly W cycles; in the cycle after it falls done_o is high, and done_o is high for one cycle only.
- R4: For a nonzero divisor, at done_o quotient_o equals floor(dividend/divisor) and remainder_o equals dividend mod divisor, both unsigned.
- R5: For a zero divisor, at done_o quotient_o has every bit set and remainder_o equals the dividend, and done_o still pulses with the normal timing.
- R6: start_i while busy_o is high has no effect: the operands of the running division are kept and its completion time does not move.
- R7: While busy_o is low and no request is accepted, quotient_o and remainder_o hold their values.
- R8: busy_o and done_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request; accepted only while idle |
| dividend_i | input | W | Unsigned dividend, sampled on acceptance |
| divisor_i | input | W | Unsigned divisor, sampled on acceptance |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle pulse when results are ready |
| quotient_o | output | W | Quotient |
| remainder_o | output | W | Remainder |

## Verification
`busy_o` is due one clock after the accepting edge, and `done_o` together with the final quotient and remainder is due W+1 clocks after it. The bench drives inputs on falling edges and samples outputs on falling edges. It walks through each intermediate cycle and checks that `busy_o` is still high and `done_o` still low. It compares the results only in the `done_o` cycle, and again one cycle later to confirm they are held. Every dividend and divisor pair of a 6-bit instance is run, zero divisors included. A sample of those runs also raises a competing request partway through, and the bench checks that the original result and timing survive it.

// File: rtl/seq_divider_pkg.sv
package seq_divider_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/seq_divider_step.sv
module seq_divider_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dsr_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] dvd_o,
  output logic [W-1:0] quo_o
);
  localparam int SW = W + 1;
  localparam int DW = W + 2;

  logic [SW-1:0] shifted;
  logic [DW-1:0] diff;
  logic          neg;

  always_comb begin
    shifted = {rem_i, dvd_i[W-1]};
    diff    = {1'b0, shifted} - {2'b00, dsr_i};
    neg     = diff[DW-1];
    // on a failed trial the shifted value is below the divisor, so it fits W bits
    rem_o   = neg ? shifted[W-1:0] : diff[W-1:0];
    quo_o   = {quo_i[W-2:0], ~neg};
    dvd_o   = {dvd_i[W-2:0], 1'b0};
  end
endmodule

// File: rtl/seq_divider_ctrl.sv
module seq_divider_ctrl
  import seq_divider_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign load_o = start_i && (state_q == ST_IDLE);
  assign step_o = (state_q == ST_RUN);
  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (cnt_q == LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
          cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o));
  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_fall_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q <= LAST));
  p_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o
);
  logic         load, step;
  logic [W-1:0] rem_q, dvd_q, quo_q, dsr_q;
  logic [W-1:0] rem_d, dvd_d, quo_d;

  seq_divider_ctrl #(.W(W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  seq_divider_step #(.W(W)) u_step (
    .rem_i(rem_q),
    .dvd_i(dvd_q),
    .quo_i(quo_q),
    .dsr_i(dsr_q),
    .rem_o(rem_d),
    .dvd_o(dvd_d),
    .quo_o(quo_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      dvd_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      dvd_q <= dividend_i;
      quo_q <= '0;
      dsr_q <= divisor_i;
    end else if (step) begin
      rem_q <= rem_d;
      dvd_q <= dvd_d;
      quo_q <= quo_d;
    end
  end

  assign quotient_o  = quo_q;
  assign remainder_o = rem_q;

  p_rem_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && dsr_q != '0) |-> (rem_q < dsr_q));
  p_ignore_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(dsr_q));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)));
endmodule

// File: tb/seq_divider_tb.sv
module seq_divider_tb;
  localparam int W = 6;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         busy, done;
  logic [W-1:0] q, r;
  int           n_checks = 0;
  int           n_fail = 0;
  int           cycles = 0;

  always #2.5 clk = ~clk;

  seq_divider #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dividend_i(a), .divisor_i(b),
    .busy_o(busy), .done_o(done),
    .quotient_o(q), .remainder_o(r)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst_n && busy && done) begin
      n_checks++; n_fail++;
      $display("FAIL R8: actual busy=1 done=1 expected not both");
    end
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  // one division; optionally a competing request mid-flight (R6)
  task automatic run_div(input int x, input int y, input bit intrude);
    logic [W-1:0] eq, er;
    if (y == 0) begin eq = '1; er = W'(x); end
    else begin eq = W'(x / y); er = W'(x % y); end
    @(negedge clk);
    a = W'(x); b = W'(y); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy", W'(busy), W'(1));
    check("R2 done", W'(done), W'(0));
    for (int i = 1; i < W; i++) begin
      if (intrude && i == 2) begin
        a = W'(x + 1); b = W'(y + 1); start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      check(intrude ? "R6 busy" : "R3 busy", W'(busy), W'(1));
      check("R3 done low", W'(done), W'(0));
    end
    @(negedge clk);
    check("R3 busy fell", W'(busy), W'(0));
    check("R3 done", W'(done), W'(1));
    check(y == 0 ? "R5 quotient" : (intrude ? "R6 quotient" : "R4 quotient"), q, eq);
    check(y == 0 ? "R5 remainder" : (intrude ? "R6 remainder" : "R4 remainder"), r, er);
    @(negedge clk);
    check("R3 done pulse", W'(done), W'(0));
    check("R7 quotient hold", q, eq);
    check("R7 remainder hold", r, er);
  endtask

  initial begin
    #1;
    check("R1 busy", W'(busy), W'(0));
    check("R1 done", W'(done), W'(0));
    check("R1 quotient", q, '0);
    check("R1 remainder", r, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 busy after release", W'(busy), W'(0));
    check("R1 quotient after release", q, '0);
    run_div(29, 3, 1'b0);
    run_div(N - 1, 1, 1'b0);
    run_div(0, 0, 1'b0);
    run_div(N - 1, 0, 1'b0);
    for (int x = 0; x < N; x++) begin
      for (int y = 0; y < N; y++) begin
        run_div(x, y, ((x + y) % 17) == 0);
      end
    end
    finish_run();
  end
endmodule